// File: doc/BRIEF.md
# Toggled Index/Data Attribute Register Port

This block is the register side of a display attribute controller. Software reaches all of its registers through one shared write address: each write is taken either as an index byte or as a data byte, and a hidden phase flip-flop decides which. The flip-flop starts in the index phase and flips on every write. A read strobe on a separate status register puts it back into the index phase. Software uses that strobe to get back into step before each index write, whatever phase it was left in.

The index byte does two jobs. Its low five bits select the target register. Bit 5 turns the video output on and, while set, locks the sixteen palette entries against writes. The block has sixteen 6-bit palette entries and five control registers: mode, border (overscan) colour, plane enable, pixel panning and colour select. A separate read strobe returns the register selected by the current index. Pixel colour mapping is handled elsewhere; this block only drives the video-enable level.

The phase machine has two states, `PH_INDEX` and `PH_DATA`. The transitions are:
- **index write**: `PH_INDEX` to `PH_DATA` on a write.
- **data write**: `PH_DATA` to `PH_INDEX` on a write.
- **status resync**: any state to `PH_INDEX` on a status read. This transition wins over both write transitions.
- **idle hold**: the phase is unchanged when neither a write nor a status read occurs.

Top module: `attr_port`

## Requirements
- R1: After reset the phase is index, `video_en` is 0, the index is 0 and every register reads 0.
- R2: From the index phase, a write loads the index and the next write loads data into the indexed register. The phase alternates on every later write.
- R3: A status read returns the phase to index at the next clock. A write in the same cycle is still handled by the phase it finds, so a combined index write and status read leaves the next write as an index write.
- R4: An index write stores bits 4:0 as the index and bit 5 as `video_en`. Bits 7:6 are ignored. `video_en` changes only on an index write.
- R5: Indices 0x00 to 0x0F are palette entries that keep data bits 5:0. Readback returns 0 in bits 7:6.
- R6: Index 0x10 (mode) and index 0x11 (border colour) keep all 8 data bits.
- R7: Index 0x12 (plane enable) and index 0x14 (colour select) keep data bits 3:0.
- R8: Index 0x13 (pixel panning) keeps data bits 2:0, the low three bits of the horizontal offset.
- R9: A data write to an index from 0x15 to 0x1F changes no register, and a read at such an index returns 0.
- R10: `rd_data` shows the register at the current index while `rd_en` is 1 and shows 0 otherwise. A read never changes the phase.
- R11: While `video_en` is 1, data writes to palette indices are dropped. Writes to indices 0x10 to 0x14 still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the shared index/data address |
| wr_data | input | 8 | Write byte |
| stat_rd | input | 1 | Status-register read strobe; returns the phase to index |
| rd_en | input | 1 | Read strobe for the data readback address |
| rd_data | output | 8 | Register selected by the current index; 0 when `rd_en` is low |
| video_en | output | 1 | Video output enable; also the palette write lock |

## Verification
The assertions check the phase rules on every cycle:
- the phase flips on a write,
- the phase holds across reads and idle cycles,
- a status read always leads to the index phase,
- `video_en` moves only on an index write,
- palette entries stay stable under a locked write,
- registers stay stable under a write to an unimplemented index.

The bench's scenarios are needed for the rest. They sweep all 32 indices to show the width mask of each register and the mapping of index to register. They also show what a combined write and status read does, and that the port stays in step when reads fall between the index and data writes.

// File: rtl/attr_pkg.sv
package attr_pkg;
    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_t;

    // register offsets; software decodes these
    localparam int ATTR_MODE  = 16;
    localparam int ATTR_BORD  = 17;
    localparam int ATTR_PLANE = 18;
    localparam int ATTR_PAN   = 19;
    localparam int ATTR_CSEL  = 20;
endpackage

// File: rtl/attr_phase_fsm.sv
module attr_phase_fsm
    import attr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  logic   stat_rd,
    output phase_t phase,
    output logic   idx_we,
    output logic   data_we
);
    phase_t phase_nx;

    always_comb begin
        phase_nx = phase;
        if (stat_rd) begin
            phase_nx = PH_INDEX;
        end else if (wr_en) begin
            unique case (phase)
                PH_INDEX: phase_nx = PH_DATA;
                PH_DATA:  phase_nx = PH_INDEX;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_INDEX;
        else        phase <= phase_nx;
    end

    always_comb begin
        idx_we  = 1'b0;
        data_we = 1'b0;
        unique case (phase)
            PH_INDEX: idx_we  = wr_en;
            PH_DATA:  data_we = wr_en;
        endcase
    end

    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stat_rd) |=> (phase != $past(phase)))
        else $error("phase did not flip on write");

    assert_resync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (phase == PH_INDEX))
        else $error("status read did not resync phase");

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !stat_rd) |=> $stable(phase))
        else $error("phase moved without a write");
endmodule

// File: rtl/attr_index_reg.sv
module attr_index_reg #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_we,
    input  logic [IDX_W-1:0] idx_in,
    input  logic             ven_in,
    output logic [IDX_W-1:0] idx,
    output logic             video_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            video_en <= 1'b0;
        end else if (idx_we) begin
            idx      <= idx_in;
            video_en <= ven_in;
        end
    end

    assert_ven_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_we |=> $stable(video_en))
        else $error("video enable changed without index write");
endmodule

// File: rtl/attr_reg_file.sv
module attr_reg_file
    import attr_pkg::*;
#(
    parameter int IDX_W     = 5,
    parameter int DATA_W    = 8,
    parameter int PAL_COUNT = 16,
    parameter int PAL_W     = 6,
    parameter int PLANE_W   = 4,
    parameter int PAN_W     = 3,
    parameter int CSEL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic              lock,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAL_AW = $clog2(PAL_COUNT);

    logic [PAL_W-1:0]   pal_q [PAL_COUNT];
    logic [DATA_W-1:0]  mode_q, bord_q;
    logic [PLANE_W-1:0] plane_q;
    logic [PAN_W-1:0]   pan_q;
    logic [CSEL_W-1:0]  csel_q;
    logic               is_pal;
    logic               is_unimpl;
    logic [DATA_W-1:0]  rd_val;

    assign is_pal    = idx < IDX_W'(PAL_COUNT);
    assign is_unimpl = idx > IDX_W'(ATTR_CSEL);

    for (genvar g = 0; g < PAL_COUNT; g++) begin : g_pal
        logic hit;
        assign hit = data_we && !lock && (idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)   pal_q[g] <= '0;
            else if (hit) pal_q[g] <= wr_data[PAL_W-1:0];
        end

        assert_pal_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (data_we && lock) |=> $stable(pal_q[g]))
            else $error("palette entry written while locked");
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            bord_q  <= '0;
            plane_q <= '0;
            pan_q   <= '0;
            csel_q  <= '0;
        end else if (data_we) begin
            if (idx == IDX_W'(ATTR_MODE))  mode_q  <= wr_data;
            if (idx == IDX_W'(ATTR_BORD))  bord_q  <= wr_data;
            if (idx == IDX_W'(ATTR_PLANE)) plane_q <= wr_data[PLANE_W-1:0];
            if (idx == IDX_W'(ATTR_PAN))   pan_q   <= wr_data[PAN_W-1:0];
            if (idx == IDX_W'(ATTR_CSEL))  csel_q  <= wr_data[CSEL_W-1:0];
        end
    end

    always_comb begin
        rd_val = '0;
        if (is_pal) begin
            rd_val = DATA_W'(pal_q[idx[PAL_AW-1:0]]);
        end else begin
            case (int'(idx))
                ATTR_MODE:  rd_val = mode_q;
                ATTR_BORD:  rd_val = bord_q;
                ATTR_PLANE: rd_val = DATA_W'(plane_q);
                ATTR_PAN:   rd_val = DATA_W'(pan_q);
                ATTR_CSEL:  rd_val = DATA_W'(csel_q);
                default:    rd_val = '0;
            endcase
        end
    end

    assign rd_data = rd_en ? rd_val : '0;

    assert_unimpl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && is_unimpl) |=> ($stable(mode_q) && $stable(bord_q) &&
            $stable(plane_q) && $stable(pan_q) && $stable(csel_q)))
        else $error("unimplemented index changed a register");
endmodule

// File: rtl/attr_port.sv
module attr_port
    import attr_pkg::*;
#(
    parameter int IDX_W     = 5,
    parameter int DATA_W    = 8,
    parameter int VEN_BIT   = 5,
    parameter int PAL_COUNT = 16,
    parameter int PAL_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_rd,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              video_en
);
    localparam int SPARE_W = DATA_W - VEN_BIT - 1;

    phase_t           phase;
    logic             idx_we, data_we;
    logic [IDX_W-1:0] idx;
    logic [SPARE_W-1:0] unused_idx_hi;

    assign unused_idx_hi = wr_data[DATA_W-1:VEN_BIT+1];

    attr_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .stat_rd (stat_rd),
        .phase   (phase),
        .idx_we  (idx_we),
        .data_we (data_we)
    );

    attr_index_reg #(.IDX_W(IDX_W)) u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_we   (idx_we),
        .idx_in   (wr_data[IDX_W-1:0]),
        .ven_in   (wr_data[VEN_BIT]),
        .idx      (idx),
        .video_en (video_en)
    );

    attr_reg_file #(
        .IDX_W     (IDX_W),
        .DATA_W    (DATA_W),
        .PAL_COUNT (PAL_COUNT),
        .PAL_W     (PAL_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_we (data_we),
        .lock    (video_en),
        .idx     (idx),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_we && data_we))
        else $error("index and data strobes together");
endmodule

// File: tb/attr_port_tb.sv
module attr_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stat_rd = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       video_en;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] model [32];

    always #2 clk = ~clk;

    attr_port u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .stat_rd  (stat_rd),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .video_en (video_en)
    );

    function automatic logic [7:0] width_mask(input int i);
        if (i < 16)                return 8'h3F;
        else if (i == 16 || i == 17) return 8'hFF;
        else if (i == 18 || i == 20) return 8'h0F;
        else if (i == 19)           return 8'h07;
        else                        return 8'h00;
    endfunction

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic resync();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1;
        #1;
        check8(rd_data, exp, req);
        rd_en = 1'b0;
    endtask

    task automatic read_idx(input int i, input logic ven, input string req);
        resync();
        wr({2'b00, ven, 5'(i)});
        rd_check(model[i], req);
    endtask

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, index 0 readable, video off
        #1;
        check8({7'd0, video_en}, 8'h00, "R1 video_en");
        rd_check(8'h00, "R1 reg0");
        // R10: rd_en low gives zero
        #1;
        check8(rd_data, 8'h00, "R10 idle read");

        // R2 R5 R6 R7 R8 R9: sweep all 32 indices with video off
        for (int i = 0; i < 32; i++) begin
            logic [7:0] pat;
            pat = 8'(i * 37 + 91);
            resync();
            wr({3'b000, 5'(i)});
            wr(pat);
            model[i] = pat & width_mask(i);
        end
        for (int i = 0; i < 32; i++) begin
            string tag;
            if (i < 16) tag = "R5";
            else if (i < 18) tag = "R6";
            else if (i == 19) tag = "R8";
            else if (i < 21) tag = "R7";
            else tag = "R9";
            read_idx(i, 1'b0, tag);
        end

        // R4: bits 7:6 ignored, bit 5 sets video
        resync();
        wr(8'hE3);
        #1;
        check8({7'd0, video_en}, 8'h01, "R4 video on");
        rd_check(model[3], "R4 index from low bits");

        // R11: palette writes dropped while video on
        for (int i = 0; i < 16; i++) begin
            resync();
            wr({3'b001, 5'(i)});
            wr(~model[i]);
        end
        for (int i = 0; i < 16; i++) read_idx(i, 1'b1, "R11 palette locked");
        resync();
        wr(8'hF0);
        wr(8'h5A);
        model[16] = 8'h5A;
        read_idx(16, 1'b1, "R11 mode writable");

        // R4: video off again with index write
        resync();
        wr(8'h02);
        #1;
        check8({7'd0, video_en}, 8'h00, "R4 video off");

        // R3: combined index write and status read keeps index phase
        resync();
        @(negedge clk);
        wr_en = 1'b1; stat_rd = 1'b1; wr_data = 8'h11;
        @(negedge clk);
        wr_en = 1'b0; stat_rd = 1'b0;
        wr(8'h12);
        wr(8'h09);
        model[18] = 8'h09;
        read_idx(18, 1'b0, "R3 plane via resync");
        read_idx(17, 1'b0, "R3 border untouched");

        // R3: status read between index and data forces next write to index
        resync();
        wr(8'h13);
        resync();
        wr(8'h14);
        wr(8'h06);
        model[20] = 8'h06;
        read_idx(20, 1'b0, "R3 csel via resync");
        read_idx(19, 1'b0, "R3 pan untouched");

        // R10: read held across a clock does not toggle phase
        resync();
        wr(8'h10);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        wr(8'hC3);
        model[16] = 8'hC3;
        read_idx(16, 1'b0, "R10 read keeps phase");

        // R2: four writes alternate index/data without resync
        resync();
        wr(8'h11); wr(8'h77);
        wr(8'h13); wr(8'hFD);
        model[17] = 8'h77;
        model[19] = 8'h05;
        read_idx(17, 1'b0, "R2 alternate a");
        read_idx(19, 1'b0, "R8 alternate b");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule